// File: doc/BRIEF.md
# Dual-Port Memory with Per-Port Write Policy

This block is a synchronous memory with two fully independent ports, A and B, that share a single storage array. Each port has its own enable, write enable, address, write data and registered read data. Only the stored words are shared between the ports.

The behaviour of each port's read register during that port's own write is fixed at build time by a parameter. The parameter takes one of three values:
- `WM_WRITE_FIRST` shows the word being written.
- `WM_READ_FIRST` shows what the word held before the write.
- `WM_NO_CHANGE` leaves the read register untouched.

A processor that must never see stray read data after a store attaches to a port set to `WM_NO_CHANGE`.

The block defines behaviour when both ports access the same word in one cycle. If both ports write that word, port A's data is stored. If one port writes and the other reads that word, the reading port gets the word's earlier contents.

Top module: `dpram_dual`

## Requirements
- R1: With enable high and write enable low, a port's read data shows the addressed word one clock edge after the address is presented.
- R2: A port built with `WM_WRITE_FIRST` that writes shows its own write data on its read data after that edge.
- R3: A port built with `WM_READ_FIRST` that writes shows the addressed word's contents from before the write.
- R4: A port built with `WM_NO_CHANGE` keeps its read data unchanged on every cycle in which it writes.
- R5: With a port's enable low, that port writes nothing and its read data holds, whatever its write enable, address and data.
- R6: When both ports write the same address in one cycle, the word afterwards holds port A's data.
- R7: When one port writes an address that the other port reads in the same cycle, the reading port returns the contents from before the write.
- R8: Writes by the two ports to different addresses in one cycle are both stored.
- R9: While `rst_ni` is low, both read data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset of the read registers |
| a_en_i | input | 1 | Port A enable |
| a_we_i | input | 1 | Port A write enable |
| a_addr_i | input | AW | Port A word address |
| a_wdata_i | input | WIDTH | Port A write data |
| a_rdata_o | output | WIDTH | Port A registered read data |
| b_en_i | input | 1 | Port B enable |
| b_we_i | input | 1 | Port B write enable |
| b_addr_i | input | AW | Port B word address |
| b_wdata_i | input | WIDTH | Port B write data |
| b_rdata_o | output | WIDTH | Port B registered read data |

## Verification
The assertions assume that addresses are always below DEPTH and that inputs are stable around the rising edge. They also assume that the storage array holds no meaningful value until it has been written. The stimulus changes inputs only on the falling edge and uses only addresses inside the array. It reads a word only after the test has written that word. The stimulus drives two instances together: one with write-first on A and read-first on B, and one with no-change on both ports. This lets a single access sequence exercise all three write policies.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  typedef enum logic [1:0] {
    WM_WRITE_FIRST = 2'd0,
    WM_READ_FIRST  = 2'd1,
    WM_NO_CHANGE   = 2'd2
  } wr_mode_e;
endpackage

// File: rtl/dpram_array.sv
module dpram_array #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             a_wr_i,
  input  logic [AW-1:0]    a_addr_i,
  input  logic [WIDTH-1:0] a_wdata_i,
  input  logic             b_wr_i,
  input  logic [AW-1:0]    b_addr_i,
  input  logic [WIDTH-1:0] b_wdata_i,
  output logic [WIDTH-1:0] a_old_o,
  output logic [WIDTH-1:0] b_old_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic same_addr, b_blocked;

  assign same_addr = (a_addr_i == b_addr_i);
  // port A has priority on a write-write collision
  assign b_blocked = a_wr_i && same_addr;

  always_ff @(posedge clk_i) begin
    if (a_wr_i) mem_q[a_addr_i] <= a_wdata_i;
    if (b_wr_i && !b_blocked) mem_q[b_addr_i] <= b_wdata_i;
  end

  // pre-edge contents, captured by the port registers
  assign a_old_o = mem_q[a_addr_i];
  assign b_old_o = mem_q[b_addr_i];

  AST_A_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_wr_i && b_wr_i && same_addr) |=> mem_q[$past(a_addr_i)] == $past(a_wdata_i)); // R6

  AST_B_STORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_wr_i && !(a_wr_i && same_addr)) |=> mem_q[$past(b_addr_i)] == $past(b_wdata_i)); // R8

  AST_A_STORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_wr_i |=> mem_q[$past(a_addr_i)] == $past(a_wdata_i)); // R8
endmodule

// File: rtl/dpram_port.sv
module dpram_port
  import dpram_pkg::*;
#(
  parameter wr_mode_e MODE  = WM_WRITE_FIRST,
  parameter int       WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             we_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [WIDTH-1:0] old_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] rdata_q, rdata_d;

  always_comb begin
    rdata_d = rdata_q;
    if (en_i) begin
      if (!we_i) begin
        rdata_d = old_i;
      end else begin
        unique case (MODE)
          WM_WRITE_FIRST: rdata_d = wdata_i;
          WM_READ_FIRST:  rdata_d = old_i;
          default:        rdata_d = rdata_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;

  AST_RESET_ZERO: assert property (@(posedge clk_i) !rst_ni |-> rdata_o == '0); // R9

  AST_DISABLED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(rdata_o)); // R5

  AST_READ_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !we_i) |=> rdata_o == $past(old_i)); // R1

  generate
    if (MODE == WM_WRITE_FIRST) begin : g_wf
      AST_WF_NEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && we_i) |=> rdata_o == $past(wdata_i)); // R2
    end else if (MODE == WM_READ_FIRST) begin : g_rf
      AST_RF_OLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && we_i) |=> rdata_o == $past(old_i)); // R3
    end else begin : g_nc
      AST_NC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && we_i) |=> $stable(rdata_o)); // R4
    end
  endgenerate
endmodule

// File: rtl/dpram_dual.sv
module dpram_dual
  import dpram_pkg::*;
#(
  parameter wr_mode_e MODE_A = WM_WRITE_FIRST,
  parameter wr_mode_e MODE_B = WM_READ_FIRST,
  parameter int       DEPTH  = 64,
  parameter int       WIDTH  = 16,
  localparam int      AW     = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             a_en_i,
  input  logic             a_we_i,
  input  logic [AW-1:0]    a_addr_i,
  input  logic [WIDTH-1:0] a_wdata_i,
  output logic [WIDTH-1:0] a_rdata_o,
  input  logic             b_en_i,
  input  logic             b_we_i,
  input  logic [AW-1:0]    b_addr_i,
  input  logic [WIDTH-1:0] b_wdata_i,
  output logic [WIDTH-1:0] b_rdata_o
);
  logic a_wr, b_wr;
  logic [WIDTH-1:0] a_old, b_old;

  assign a_wr = a_en_i && a_we_i;
  assign b_wr = b_en_i && b_we_i;

  dpram_array #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_array (
    .clk_i, .rst_ni,
    .a_wr_i(a_wr), .a_addr_i, .a_wdata_i,
    .b_wr_i(b_wr), .b_addr_i, .b_wdata_i,
    .a_old_o(a_old), .b_old_o(b_old)
  );

  dpram_port #(.MODE(MODE_A), .WIDTH(WIDTH)) u_port_a (
    .clk_i, .rst_ni, .en_i(a_en_i), .we_i(a_we_i),
    .wdata_i(a_wdata_i), .old_i(a_old), .rdata_o(a_rdata_o)
  );

  dpram_port #(.MODE(MODE_B), .WIDTH(WIDTH)) u_port_b (
    .clk_i, .rst_ni, .en_i(b_en_i), .we_i(b_we_i),
    .wdata_i(b_wdata_i), .old_i(b_old), .rdata_o(b_rdata_o)
  );

  AST_B_READS_OLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_wr && b_en_i && !b_we_i && a_addr_i == b_addr_i) |=> b_rdata_o == $past(a_old)); // R7

  AST_A_READS_OLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_wr && a_en_i && !a_we_i && a_addr_i == b_addr_i) |=> a_rdata_o == $past(b_old)); // R7
endmodule

// File: tb/tb_dpram_dual.sv
module tb_dpram_dual;
  import dpram_pkg::*;
  localparam int DEPTH = 64;
  localparam int WIDTH = 16;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic a_en = 0, a_we = 0, b_en = 0, b_we = 0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [WIDTH-1:0] a_wd = '0, b_wd = '0;
  logic [WIDTH-1:0] wf_a, rf_b, nc_a, nc_b;
  int checks = 0, errors = 0;
  logic [WIDTH-1:0] exp_mem [DEPTH];

  always #10 clk = ~clk;

  dpram_dual #(.MODE_A(WM_WRITE_FIRST), .MODE_B(WM_READ_FIRST), .DEPTH(DEPTH), .WIDTH(WIDTH)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .a_en_i(a_en), .a_we_i(a_we), .a_addr_i(a_addr), .a_wdata_i(a_wd), .a_rdata_o(wf_a),
    .b_en_i(b_en), .b_we_i(b_we), .b_addr_i(b_addr), .b_wdata_i(b_wd), .b_rdata_o(rf_b)
  );

  dpram_dual #(.MODE_A(WM_NO_CHANGE), .MODE_B(WM_NO_CHANGE), .DEPTH(DEPTH), .WIDTH(WIDTH)) dut_nc (
    .clk_i(clk), .rst_ni(rst_ni),
    .a_en_i(a_en), .a_we_i(a_we), .a_addr_i(a_addr), .a_wdata_i(a_wd), .a_rdata_o(nc_a),
    .b_en_i(b_en), .b_we_i(b_we), .b_addr_i(b_addr), .b_wdata_i(b_wd), .b_rdata_o(nc_b)
  );

  task automatic check(input string req, input logic [WIDTH-1:0] got, input logic [WIDTH-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  // drive on falling edge, one rising edge, return at next falling edge
  task automatic cyc(input logic ea, input logic wa, input int aa, input logic [WIDTH-1:0] da,
                     input logic eb, input logic wb, input int ab, input logic [WIDTH-1:0] db);
    a_en = ea; a_we = wa; a_addr = AW'(aa); a_wd = da;
    b_en = eb; b_we = wb; b_addr = AW'(ab); b_wd = db;
    @(negedge clk);
    a_en = 0; a_we = 0; b_en = 0; b_we = 0;
  endtask

  task automatic t_reset;
    check("R9 a", wf_a, '0); check("R9 b", rf_b, '0);
    check("R9 nc_a", nc_a, '0); check("R9 nc_b", nc_b, '0);
  endtask

  task automatic t_fill_and_read;
    for (int i = 0; i < 16; i++) begin
      exp_mem[i] = WIDTH'(16'h1000 + i * 16'h0111);
      cyc(1, 1, i, exp_mem[i], 0, 0, 0, '0);
    end
    for (int i = 0; i < 16; i++) begin
      cyc(1, 0, i, '0, 1, 0, 15 - i, '0);
      check("R1 a", wf_a, exp_mem[i]);
      check("R1 b", rf_b, exp_mem[15 - i]);
      check("R1 nc_a", nc_a, exp_mem[i]);
    end
  endtask

  task automatic t_write_first;
    logic [WIDTH-1:0] prev_nc;
    cyc(1, 0, 3, '0, 0, 0, 0, '0);
    prev_nc = nc_a;
    cyc(1, 1, 5, 16'hA5A5, 0, 0, 0, '0);
    exp_mem[5] = 16'hA5A5;
    check("R2", wf_a, 16'hA5A5);
    check("R4 a", nc_a, prev_nc);
  endtask

  task automatic t_read_first;
    logic [WIDTH-1:0] prev_nc;
    cyc(0, 0, 0, '0, 1, 0, 2, '0);
    prev_nc = nc_b;
    cyc(0, 0, 0, '0, 1, 1, 6, 16'h5A5A);
    check("R3", rf_b, exp_mem[6]);
    check("R4 b", nc_b, prev_nc);
    exp_mem[6] = 16'h5A5A;
    cyc(0, 0, 0, '0, 1, 0, 6, '0);
    check("R3 stored", rf_b, 16'h5A5A);
  endtask

  task automatic t_enable_low;
    logic [WIDTH-1:0] pa, pb;
    pa = wf_a; pb = rf_b;
    cyc(0, 1, 7, 16'hDEAD, 0, 1, 8, 16'hBEEF);
    check("R5 a hold", wf_a, pa);
    check("R5 b hold", rf_b, pb);
    cyc(1, 0, 7, '0, 1, 0, 8, '0);
    check("R5 a no write", wf_a, exp_mem[7]);
    check("R5 b no write", rf_b, exp_mem[8]);
  endtask

  task automatic t_write_collide;
    cyc(1, 1, 9, 16'h1111, 1, 1, 9, 16'h2222);
    exp_mem[9] = 16'h1111;
    cyc(1, 0, 9, '0, 1, 0, 9, '0);
    check("R6 a", wf_a, 16'h1111);
    check("R6 b", rf_b, 16'h1111);
  endtask

  task automatic t_read_write_same;
    logic [WIDTH-1:0] old10, old11;
    old10 = exp_mem[10]; old11 = exp_mem[11];
    cyc(1, 1, 10, 16'h3333, 1, 0, 10, '0);
    check("R7 b reads old", rf_b, old10);
    exp_mem[10] = 16'h3333;
    cyc(1, 0, 11, '0, 1, 1, 11, 16'h4444);
    check("R7 a reads old", wf_a, old11);
    exp_mem[11] = 16'h4444;
    cyc(1, 0, 10, '0, 1, 0, 11, '0);
    check("R7 new a", wf_a, 16'h3333);
    check("R7 new b", rf_b, 16'h4444);
  endtask

  task automatic t_independent;
    cyc(1, 1, 12, 16'h7777, 1, 1, 13, 16'h8888);
    exp_mem[12] = 16'h7777; exp_mem[13] = 16'h8888;
    cyc(1, 0, 13, '0, 1, 0, 12, '0);
    check("R8 a", wf_a, 16'h8888);
    check("R8 b", rf_b, 16'h7777);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_ni = 1'b1;
    @(negedge clk);
    t_fill_and_read;
    t_write_first;
    t_read_first;
    t_enable_low;
    t_write_collide;
    t_read_write_same;
    t_independent;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule